// File: doc/BRIEF.md
# Destructive-Readout Storage Cycle Controller

This block models a word-organised storage module whose read operation destroys the addressed word. Every read must therefore be followed by a write cycle that regenerates the word. The block accepts a single call pulse per storage cycle. From an internal interlock it decides whether that cycle is a read or a write. After every completed cycle it flips that choice, so the caller cannot break the read/restore pairing. A reset sets the interlock so that the first cycle is a read.

The block holds a 9-bit storage data register. It holds no address register: the caller presents the address on `addr_i` and keeps it steady for the whole cycle. A read latches the word into the data register and clears the location. The following write cycle stores the data register at the address presented then. Before storing, the write cycle can optionally reload the data register from the input bus. Storage is one bank or two chained banks, and the rated capacity is set by a parameter. The block flags any address at or above that capacity as invalid and never lets it touch the array. For the full-size configurations, set `BANK_DEPTH` to 8192, 16384 or 32768 and set `RATED_WORDS` to match. The defaults are scaled down. The cycle time and the access time are clock counts.

Top module: `sdc_storage`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rdata_vld_o`, `addr_err_o` and `proto_err_o` are 0, and `next_wr_o` is 0, meaning the first cycle will be a read.
- R2: A call sampled while idle starts exactly one cycle. `busy_o` stays high for exactly `CYCLE_CLKS` clocks after the accepting edge. `done_o` pulses high for one clock on the edge where `busy_o` falls.
- R3: The cycle type is the opposite of the type of the last completed cycle. `next_wr_o` (1 = write) toggles only when a cycle completes.
- R4: In a read cycle, `rdata_o` holds the addressed word and `rdata_vld_o` rises `ACCESS_CLKS` clocks after the accepting edge. The location then reads back as 0 until it is written again.
- R5: A write cycle with `wdata_vld_i` low stores the storage data register unchanged, which is the word read in the previous cycle.
- R6: A write cycle with `wdata_vld_i` high at the accepting edge loads `wdata_i` into the storage data register, and that value is stored.
- R7: An address at or above `RATED_WORDS` holds `addr_err_o` high for that cycle. A read at such an address returns 0 with `rdata_vld_o` high. No location is cleared or written, and the cycle still toggles the read/write interlock.
- R8: A call sampled while busy is ignored: the cycle length does not change and no extra cycle starts. On the next clock `proto_err_o` pulses for one clock.
- R9: With `CHAINED`=1, addresses below and above `BANK_DEPTH` select separate banks. The bank is chosen by address bit `log2(BANK_DEPTH)`, so words that share their low address bits do not alias.
- R10: `rdata_vld_o` is never high in a write cycle. It falls on the edge that ends the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_i | input | 1 | Cycle call, sampled on each rising edge |
| addr_i | input | ADDR_W | Word address, held stable by the caller for the whole cycle |
| wdata_i | input | WORD_W | Replacement data for a write cycle |
| wdata_vld_i | input | 1 | At a write call, load `wdata_i` instead of regenerating |
| busy_o | output | 1 | A cycle is in progress |
| next_wr_o | output | 1 | Type of the next cycle: 1 write, 0 read |
| rdata_o | output | WORD_W | Storage data register |
| rdata_vld_o | output | 1 | Read data valid, from the access point to the end of the read cycle |
| done_o | output | 1 | One-clock pulse at the end of each cycle |
| addr_err_o | output | 1 | Current cycle addresses beyond the rated capacity |
| proto_err_o | output | 1 | One-clock pulse after a call was sampled while busy |

## Verification
The hardest case to reach is destruction itself. A plain read/write pair at one address always restores the word, so the loss is never seen. The bench moves the read word elsewhere by presenting a different address during the regenerating write, then reads the first address again and expects zero. The same idea proves bank separation and the harmlessness of invalid addresses. A word is moved into the upper bank, or an out-of-range address is used that shares low bits with a live word. The live word is then read back afterwards. Calls are also injected mid-cycle and on the last busy clock, and the bench checks that the cycle length and the alternation stay untouched.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic {
    CYC_READ  = 1'b0,
    CYC_WRITE = 1'b1
  } cyc_kind_e;
endpackage

// File: rtl/sdc_rst_sync.sv
module sdc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/sdc_sequencer.sv
module sdc_sequencer
  import sdc_pkg::*;
#(
  parameter int CYCLE_CLKS  = 120,
  parameter int ACCESS_CLKS = 47
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      call_i,
  output logic      busy_o,
  output cyc_kind_e kind_o,
  output cyc_kind_e next_kind_o,
  output logic      start_o,
  output logic      access_o,
  output logic      finish_o,
  output logic      done_o,
  output logic      proto_err_o
);
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACCESS_CLKS - 1);
  localparam logic [CNT_W-1:0] CYC_LAST = CNT_W'(CYCLE_CLKS - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  cyc_kind_e        kind_q, kind_d;
  cyc_kind_e        next_q, next_d;
  logic             done_q, done_d;
  logic             perr_q, perr_d;

  // next-state
  always_comb begin
    start_o  = call_i & ~busy_q;
    access_o = busy_q & (cnt_q == ACC_LAST);
    finish_o = busy_q & (cnt_q == CYC_LAST);
    cnt_en   = start_o | busy_q;
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    kind_d   = kind_q;
    next_d   = next_q;
    if (start_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      kind_d = next_q;
    end else if (finish_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
      next_d = (next_q == CYC_READ) ? CYC_WRITE : CYC_READ;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
    done_d = finish_o;
    perr_d = call_i & busy_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= CYC_READ;
      next_q <= CYC_READ;
      done_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (start_o) kind_q <= kind_d;
      if (finish_o) next_q <= next_d;
      done_q <= done_d;
      perr_q <= perr_d;
    end
  end

  assign busy_o      = busy_q;
  assign kind_o      = kind_q;
  assign next_kind_o = next_q;
  assign done_o      = done_q;
  assign proto_err_o = perr_q;

  p_done_at_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(CYCLE_CLKS)));
  p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (next_q != $past(next_q)));
  p_kind_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(next_q));
  p_perr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |-> $past(busy_q));
endmodule

// File: rtl/sdc_addr_map.sv
module sdc_addr_map #(
  parameter int ADDR_W      = 11,
  parameter int BANK_AW     = 9,
  parameter int NUM_BANKS   = 2,
  parameter int IDX_W       = 1,
  parameter int RATED_WORDS = 768
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [BANK_AW-1:0] bank_addr_o,
  output logic [IDX_W-1:0]   bank_idx_o,
  output logic               invalid_o
);
  assign bank_addr_o = addr_i[BANK_AW-1:0];
  assign invalid_o   = (32'(addr_i) >= 32'(RATED_WORDS));

  generate
    if (NUM_BANKS > 1) begin : g_chain
      assign bank_idx_o = addr_i[BANK_AW +: IDX_W];
    end else begin : g_single
      assign bank_idx_o = '0;
    end
  endgenerate
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 512,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              clr_en,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)       mem[addr] <= wdata;
    else if (clr_en) mem[addr] <= '0;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/sdc_storage.sv
module sdc_storage
  import sdc_pkg::*;
#(
  parameter int WORD_W      = 9,
  parameter int BANK_DEPTH  = 512,
  parameter int CHAINED     = 1,
  parameter int RATED_WORDS = 768,
  parameter int ADDR_W      = 11,
  parameter int CYCLE_CLKS  = 120,
  parameter int ACCESS_CLKS = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              wdata_vld_i,
  output logic              busy_o,
  output logic              next_wr_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_vld_o,
  output logic              done_o,
  output logic              addr_err_o,
  output logic              proto_err_o
);
  localparam int NUM_BANKS = (CHAINED != 0) ? 2 : 1;
  localparam int BANK_AW   = $clog2(BANK_DEPTH);
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              rst_sn;
  logic              start, access, finish;
  cyc_kind_e         kind, next_kind;
  logic [BANK_AW-1:0] bank_addr;
  logic [IDX_W-1:0]  bank_idx;
  logic              addr_bad;
  logic [WORD_W-1:0] bank_rd [NUM_BANKS];
  logic [WORD_W-1:0] sel_rd;
  logic              clr_any, wr_any;

  logic [WORD_W-1:0] sdr_q, sdr_d;
  logic              sdr_en;
  logic              vld_q, vld_d;
  logic              err_q, err_d;

  sdc_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_sn(rst_sn)
  );

  sdc_sequencer #(
    .CYCLE_CLKS (CYCLE_CLKS),
    .ACCESS_CLKS(ACCESS_CLKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .call_i     (call_i),
    .busy_o     (busy_o),
    .kind_o     (kind),
    .next_kind_o(next_kind),
    .start_o    (start),
    .access_o   (access),
    .finish_o   (finish),
    .done_o     (done_o),
    .proto_err_o(proto_err_o)
  );

  sdc_addr_map #(
    .ADDR_W     (ADDR_W),
    .BANK_AW    (BANK_AW),
    .NUM_BANKS  (NUM_BANKS),
    .IDX_W      (IDX_W),
    .RATED_WORDS(RATED_WORDS)
  ) u_map (
    .addr_i     (addr_i),
    .bank_addr_o(bank_addr),
    .bank_idx_o (bank_idx),
    .invalid_o  (addr_bad)
  );

  assign clr_any = access & (kind == CYC_READ) & ~err_q;
  assign wr_any  = finish & (kind == CYC_WRITE) & ~err_q;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (bank_idx == IDX_W'(b));
      sdc_bank #(
        .WORD_W(WORD_W),
        .DEPTH (BANK_DEPTH),
        .AW    (BANK_AW)
      ) u_bank (
        .clk   (clk),
        .clr_en(clr_any & hit),
        .wr_en (wr_any & hit),
        .addr  (bank_addr),
        .wdata (sdr_q),
        .rdata (bank_rd[b])
      );
    end
  endgenerate

  assign sel_rd = bank_rd[bank_idx];

  // next-state for the data register and flags
  always_comb begin
    sdr_d  = sdr_q;
    sdr_en = 1'b0;
    vld_d  = vld_q;
    err_d  = err_q;
    if (start) begin
      err_d = addr_bad;
      if ((next_kind == CYC_WRITE) && wdata_vld_i) begin
        sdr_d  = wdata_i;
        sdr_en = 1'b1;
      end
    end
    if (access && (kind == CYC_READ)) begin
      sdr_d  = err_q ? '0 : sel_rd;
      sdr_en = 1'b1;
      vld_d  = 1'b1;
    end
    if (finish) begin
      vld_d = 1'b0;
      err_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sdr_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (sdr_en) sdr_q <= sdr_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign next_wr_o   = (next_kind == CYC_WRITE);
  assign rdata_o     = sdr_q;
  assign rdata_vld_o = vld_q;
  assign addr_err_o  = err_q;

  p_vld_read_only_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    rdata_vld_o |-> (busy_o && (kind == CYC_READ)));
  p_zero_on_invalid_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (rdata_vld_o && addr_err_o) |-> (rdata_o == '0));
  p_err_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    addr_err_o |-> busy_o);
  p_no_clr_and_wr_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    !(clr_any && wr_any));
  p_vld_rise_busy_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(rdata_vld_o) |-> ($past(busy_o) && busy_o));
endmodule

// File: tb/sdc_storage_tb.sv
module sdc_storage_tb;
  localparam int WORD_W = 9;
  localparam int ADDR_W = 11;
  localparam int CYC    = 120;
  localparam int ACC    = 47;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              call_i;
  logic [ADDR_W-1:0] addr_i;
  logic [WORD_W-1:0] wdata_i;
  logic              wdata_vld_i;
  logic              busy_o, next_wr_o, rdata_vld_o, done_o, addr_err_o, proto_err_o;
  logic [WORD_W-1:0] rdata_o;

  int  total = 0;
  int  bad   = 0;
  bit  exp_wr = 1'b0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  sdc_storage u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wdata_vld_i(wdata_vld_i), .busy_o(busy_o),
    .next_wr_o(next_wr_o), .rdata_o(rdata_o), .rdata_vld_o(rdata_vld_o),
    .done_o(done_o), .addr_err_o(addr_err_o), .proto_err_o(proto_err_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One full storage cycle; poke>0 raises a stray call after sample poke.
  task automatic run_cycle(input int addr, input int wd, input bit wvld,
                           input bit exp_err, input bit chk, input int exp_data,
                           input int poke);
    bit busy_ok = 1, done_ok = 1, vld_ok = 1, err_ok = 1, perr_ok = 1;
    logic [WORD_W-1:0] got = '0;
    @(negedge clk);
    check(next_wr_o == exp_wr, "R3 cycle type", next_wr_o, exp_wr);
    addr_i = ADDR_W'(addr); wdata_i = WORD_W'(wd); wdata_vld_i = wvld;
    call_i = 1'b1;
    @(posedge clk); #1;
    call_i = 1'b0; wdata_vld_i = 1'b0; wdata_i = '0;
    check(busy_o == 1'b1, "R2 busy after call", busy_o, 1);
    for (int k = 1; k <= CYC; k++) begin
      @(posedge clk); #1;
      if (busy_o != (k < CYC)) busy_ok = 0;
      if (done_o != (k == CYC)) done_ok = 0;
      if (rdata_vld_o != (!exp_wr && k >= ACC && k < CYC)) vld_ok = 0;
      if (addr_err_o != (exp_err && k < CYC)) err_ok = 0;
      if (proto_err_o != (poke > 0 && k == poke + 1)) perr_ok = 0;
      if (k == ACC) got = rdata_o;
      if (poke > 0 && k == poke) call_i = 1'b1;
      if (poke > 0 && k == poke + 1) call_i = 1'b0;
    end
    check(busy_ok, "R2 busy length", busy_ok, 1);
    check(done_ok, "R2 done pulse", done_ok, 1);
    check(vld_ok, exp_wr ? "R10 no valid in write" : "R4 access timing", vld_ok, 1);
    check(err_ok, "R7 address error flag", err_ok, 1);
    check(perr_ok, "R8 protocol error pulse", perr_ok, 1);
    if (chk) check(got == WORD_W'(exp_data), "R4 read data", got, exp_data);
    exp_wr = ~exp_wr;
  endtask

  task automatic t_reset;
    check(busy_o == 0 && done_o == 0 && rdata_vld_o == 0, "R1 idle outputs",
          {busy_o, done_o, rdata_vld_o}, 0);
    check(addr_err_o == 0 && proto_err_o == 0, "R1 error flags",
          {addr_err_o, proto_err_o}, 0);
    check(next_wr_o == 0, "R1 first cycle read", next_wr_o, 0);
  endtask

  task automatic t_basic;   // R5 R6
    run_cycle(5, 0, 0, 0, 0, 0, 0);
    run_cycle(5, 'h1A5, 1, 0, 0, 0, 0);     // R6 load from bus
    run_cycle(5, 0, 0, 0, 1, 'h1A5, 0);
    run_cycle(5, 'h0AA, 0, 0, 0, 0, 0);     // R5 bus ignored, regenerate
    run_cycle(5, 0, 0, 0, 1, 'h1A5, 0);
    run_cycle(5, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_destructive;  // R4
    run_cycle(5, 0, 0, 0, 1, 'h1A5, 0);
    run_cycle(6, 0, 0, 0, 0, 0, 0);         // word moved to 6
    run_cycle(5, 0, 0, 0, 1, 0, 0);         // R4 cleared by read
    run_cycle(5, 'h0FF, 1, 0, 0, 0, 0);
  endtask

  task automatic t_banks;   // R9
    run_cycle(6, 0, 0, 0, 1, 'h1A5, 0);
    run_cycle(518, 0, 0, 0, 0, 0, 0);
    run_cycle(5, 0, 0, 0, 1, 'h0FF, 0);
    run_cycle(5, 0, 0, 0, 0, 0, 0);
    run_cycle(6, 0, 0, 0, 1, 0, 0);         // R9 upper bank did not alias
    run_cycle(6, 'h123, 1, 0, 0, 0, 0);
    run_cycle(518, 0, 0, 0, 1, 'h1A5, 0);   // R9 upper bank word intact
    run_cycle(518, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_invalid;  // R7
    run_cycle(800, 0, 0, 1, 1, 0, 0);
    run_cycle(1029, 'h055, 1, 1, 0, 0, 0);
    run_cycle(5, 0, 0, 0, 1, 'h0FF, 0);     // R7 no write through alias
    run_cycle(5, 0, 0, 0, 0, 0, 0);
    run_cycle(1030, 0, 0, 1, 1, 0, 0);
    run_cycle(1030, 0, 0, 1, 0, 0, 0);
    run_cycle(6, 0, 0, 0, 1, 'h123, 0);     // R7 no clear through alias
    run_cycle(6, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_busy_call;  // R8
    run_cycle(6, 0, 0, 0, 1, 'h123, 10);
    run_cycle(6, 0, 0, 0, 0, 0, CYC - 1);
    run_cycle(6, 0, 0, 0, 1, 'h123, 0);
    run_cycle(6, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; call_i = 1'b0; addr_i = '0; wdata_i = '0; wdata_vld_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_basic();
    t_destructive();
    t_banks();
    t_invalid();
    t_busy_call();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule